// File: doc/BRIEF.md
# Serial EEPROM Slave with SPI Access

This block behaves as a small byte-wide serial EEPROM that an SPI master reaches over four pins: serial clock, active-low chip select, master-out data and master-in data. A system clock oversamples the pins through synchronisers. Every transfer starts with an 8-bit opcode. The opcode may be followed by an address and by data. The block decodes these commands:

- set and clear of a write-enable latch,
- read and write of a status register,
- sequential array reads,
- array writes.

All array transfers are confined to one aligned block of `BLOCK` words. A completed write is followed by a programming interval of `PROG_CYCLES` system clocks. During that interval the device reports itself busy and obeys only the status-read command.

With `ADDR9 = 1` the array can hold up to 512 words. In that case a ninth address bit travels in bit 3 of the read or write opcode, and a single address byte follows the opcode. The array contents reset to zero, which stands in for a blank part.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the status register reads 0x00, every array word reads 0x00, and MISO is 0.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch state appears in status bit 1.
- R3: Opcode 0x03 is a read, followed by one address byte; data then comes out MSB first in SPI mode 0. In the base configuration only address bits 6:0 are used. After each byte the address advances, and it wraps to the start of the same 8-word block.
- R4: Opcode 0x02 with the latch set is a write, followed by an address byte. Each complete data byte is stored, and the address wraps inside its 8-word block.
- R5: An array write or a status write (opcode 0x01) issued while the latch is clear changes nothing.
- R6: A status write stores data bit 7 into status bit 7 and data bits 4:2 into status bits 4:2. Status bits 6:5 always read 0.
- R7: Deselecting after a write that carried at least one data byte clears the latch. It also sets status bit 0 (busy) for `PROG_CYCLES` clocks.
- R8: While busy, every opcode except 0x05 is ignored. A read during this time returns 0 bits.
- R9: MISO is 0 whenever chip select is high.
- R10: With `ADDR9 = 1`, opcode bit 3 is address bit 8. The read and write opcodes are decoded with bit 3 masked, so 0x0B reads and 0x0A writes the upper 256 words.
- R11: Opcode 0x05 returns the current status byte, repeated for as long as clocks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 when deselected |

## Verification
Assertions check every cycle that the array is written only while the latch is set and the device is not busy. They also check that the latch is already clear when busy rises, that busy cannot drop before its counter runs out, and that the block bits of the address never change while a read or write stream is running. Only the bench scenarios can show the contents of each byte: the wrap order of data, the status encoding, and the rejection of commands during the programming interval. The bench also covers the masked decode of the nine-bit variant, which it tests on a second instance. For these it compares each received byte against a behavioural model, and it checks the deselected output on every clock.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_ARR_WR   = 8'h02;
    localparam logic [7:0] OP_ARR_RD   = 8'h03;
    localparam logic [7:0] OP_LATCH_CL = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_LATCH_ST = 8'h06;

    // bits of the status byte that a status write may change
    localparam logic [7:0] STAT_WR_MASK = 8'h9C;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDR,
        PH_RD,
        PH_WR,
        PH_STRD,
        PH_STWR,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_end,
    output logic mosi_s
);

    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES:0]   csn;
        logic [STAGES-1:0] sdi;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d     = q;
        d.sck = {q.sck[STAGES-1:0], sclk};
        d.csn = {q.csn[STAGES-1:0], cs_n};
        d.sdi = {q.sdi[STAGES-2:0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck <= '0;
            q.csn <= '1;
            q.sdi <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = q.sck[STAGES-1] & ~q.sck[STAGES];
    assign sclk_fall = ~q.sck[STAGES-1] & q.sck[STAGES];
    assign cs_start  = ~q.csn[STAGES-1] & q.csn[STAGES];
    assign cs_end    = q.csn[STAGES-1] & ~q.csn[STAGES];
    assign mosi_s    = q.sdi[STAGES-1];

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int WORDS = 128,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cell_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[addr] <= wdata;
        end
    end

    assign rdata = cell_q[addr];

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
    import eeprom_spi_pkg::*;
#(
    parameter int WORDS       = 128,
    parameter int BLOCK       = 8,
    parameter bit ADDR9       = 1'b0,
    parameter int PROG_CYCLES = 64,
    localparam int AW         = $clog2(WORDS),
    localparam int BW         = $clog2(BLOCK),
    localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_start,
    input  logic          cs_end,
    input  logic          mosi_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          miso_o
);

    localparam logic [7:0] OP_MASK = ADDR9 ? 8'hF7 : 8'hFF;

    typedef struct packed {
        phase_e        st;
        logic [2:0]    bitcnt;
        logic [7:0]    shin;
        logic [7:0]    tx;
        logic          miso;
        logic [AW-1:0] addr;
        logic [7:0]    op;
        logic          fetch;
        logic          wel;
        logic          wpen;
        logic [2:0]    bp;
        logic [7:0]    stnew;
        logic          stgot;
        logic          wrote;
        logic          busy;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t q, d;

    logic [7:0] byte_in;
    logic [8:0] full_addr;
    logic [7:0] status;

    function automatic logic [AW-1:0] blk_next(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        r         = a;
        r[BW-1:0] = a[BW-1:0] + 1'b1;
        return r;
    endfunction

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        byte_in   = {q.shin[6:0], mosi_s};
        full_addr = {(ADDR9 ? q.op[3] : 1'b0), byte_in};
        status    = {q.wpen, 2'b00, q.bp, q.wel, q.busy};

        if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) d.busy = 1'b0;
        end

        if (q.fetch) begin
            d.tx    = mem_rdata;
            d.addr  = blk_next(q.addr);
            d.fetch = 1'b0;
        end

        if (cs_start) begin
            d.st     = PH_OPCODE;
            d.bitcnt = '0;
            d.tx     = '0;
            d.miso   = 1'b0;
            d.wrote  = 1'b0;
            d.stgot  = 1'b0;
            d.fetch  = 1'b0;
        end else if (cs_end) begin
            if (q.st != PH_IDLE && (q.wrote || q.stgot)) begin
                if (q.stgot) begin
                    d.wpen = q.stnew[7];
                    d.bp   = q.stnew[4:2];
                end
                d.wel  = 1'b0;
                d.busy = 1'b1;
                d.cnt  = CW'(PROG_CYCLES);
            end
            d.st    = PH_IDLE;
            d.miso  = 1'b0;
            d.wrote = 1'b0;
            d.stgot = 1'b0;
            d.fetch = 1'b0;
        end else if (q.st != PH_IDLE) begin
            if (sclk_fall) begin
                d.miso = q.tx[7];
                d.tx   = {q.tx[6:0], 1'b0};
            end
            if (sclk_rise) begin
                d.shin   = byte_in;
                d.bitcnt = q.bitcnt + 1'b1;
                if (q.bitcnt == 3'd7) begin
                    case (q.st)
                        PH_OPCODE: begin
                            d.op = byte_in;
                            d.st = PH_SKIP;
                            if (q.busy) begin
                                if (byte_in == OP_STAT_RD) begin
                                    d.st = PH_STRD;
                                    d.tx = status;
                                end
                            end else if ((byte_in & OP_MASK) == OP_ARR_RD) begin
                                d.st = PH_ADDR;
                            end else if ((byte_in & OP_MASK) == OP_ARR_WR) begin
                                if (q.wel) d.st = PH_ADDR;
                            end else if (byte_in == OP_LATCH_ST) begin
                                d.wel = 1'b1;
                            end else if (byte_in == OP_LATCH_CL) begin
                                d.wel = 1'b0;
                            end else if (byte_in == OP_STAT_RD) begin
                                d.st = PH_STRD;
                                d.tx = status;
                            end else if (byte_in == OP_STAT_WR) begin
                                if (q.wel) d.st = PH_STWR;
                            end
                        end
                        PH_ADDR: begin
                            d.addr = full_addr[AW-1:0];
                            if ((q.op & OP_MASK) == OP_ARR_RD) begin
                                d.st    = PH_RD;
                                d.fetch = 1'b1;
                            end else begin
                                d.st = PH_WR;
                            end
                        end
                        PH_RD: begin
                            d.fetch = 1'b1;
                        end
                        PH_WR: begin
                            mem_we    = 1'b1;
                            mem_wdata = byte_in;
                            d.addr    = blk_next(q.addr);
                            d.wrote   = 1'b1;
                        end
                        PH_STRD: begin
                            d.tx = status;
                        end
                        PH_STWR: begin
                            d.stnew = byte_in & STAT_WR_MASK;
                            d.stgot = 1'b1;
                            d.st    = PH_SKIP;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_addr = q.addr;
    assign miso_o   = q.miso;

    AST_WE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> q.wel);  // R5

    AST_NO_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !q.busy);  // R8

    AST_LATCH_CLEAR_AT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !q.wel);  // R7

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt > CW'(1)) |=> q.busy);  // R7

    AST_WR_STAYS_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_WR && $past(q.st) == PH_WR) |-> (q.addr >> BW) == ($past(q.addr) >> BW));  // R4

    AST_RD_STAYS_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_RD && $past(q.st) == PH_RD) |-> (q.addr >> BW) == ($past(q.addr) >> BW));  // R3

endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
    parameter int WORDS       = 128,
    parameter int BLOCK       = 8,
    parameter bit ADDR9       = 1'b0,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(WORDS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);

    logic          sclk_rise, sclk_fall, cs_start, cs_end, mosi_s;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          miso_int;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .mosi_s    (mosi_s)
    );

    eeprom_ctrl #(
        .WORDS       (WORDS),
        .BLOCK       (BLOCK),
        .ADDR9       (ADDR9),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .mosi_s    (mosi_s),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .miso_o    (miso_int)
    );

    eeprom_array #(.WORDS(WORDS), .WIDTH(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign miso = miso_int & ~cs_n;

endmodule

// File: tb/test_eeprom_spi_slave.sv
`timescale 1ns/1ps
module test_eeprom_spi_slave;

    localparam int HALF = 4;
    localparam int PROG = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic cs0 = 1'b1;
    logic cs1 = 1'b1;
    logic miso0, miso1;

    int tests = 0;
    int fails = 0;
    longint cyc = 0;
    bit done = 0;

    logic [7:0] mm [2][512];
    bit         wel [2];
    logic [7:0] nv  [2];
    bit         bon [2];
    longint     bt  [2];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eeprom_spi_slave #(.WORDS(128), .BLOCK(8), .ADDR9(1'b0), .PROG_CYCLES(PROG)) i_eeprom_spi_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs0), .mosi(mosi), .miso(miso0));

    eeprom_spi_slave #(.WORDS(512), .BLOCK(8), .ADDR9(1'b1), .PROG_CYCLES(PROG)) i_eeprom_spi_slave_a9 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs1), .mosi(mosi), .miso(miso1));

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    // R9: deselected output compared every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cs0) check("R9 miso idle dev0", {7'd0, miso0}, 8'd0);
            if (cs1) check("R9 miso idle dev1", {7'd0, miso1}, 8'd0);
        end
    end

    function automatic bit mbusy(input int w);
        return bon[w] && (cyc - bt[w] < PROG);
    endfunction

    function automatic logic [7:0] mstat(input int w);
        return {nv[w][7], 2'b00, nv[w][4:2], wel[w], mbusy(w)};
    endfunction

    function automatic int wrapa(input int a);
        return (a & ~7) | ((a + 1) & 7);
    endfunction

    task automatic sbyte(input int w, input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = (w == 0) ? miso0 : miso1;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic sel(input int w);
        @(negedge clk);
        if (w == 0) cs0 = 1'b0; else cs1 = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel(input int w);
        repeat (HALF) @(negedge clk);
        if (w == 0) cs0 = 1'b1; else cs1 = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic rdsr(input int w, input int n, input string tag);
        logic [7:0] r;
        sel(w);
        sbyte(w, 8'h05, r);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = mstat(w);
            sbyte(w, 8'h00, r);
            check(tag, r, e);
        end
        desel(w);
    endtask

    task automatic latch(input int w, input logic [7:0] op);
        logic [7:0] r;
        bit b;
        sel(w);
        b = mbusy(w);
        sbyte(w, op, r);
        if (!b) wel[w] = (op == 8'h06);
        desel(w);
    endtask

    task automatic wrsr(input int w, input logic [7:0] v);
        logic [7:0] r;
        bit ok;
        sel(w);
        ok = !mbusy(w) && wel[w];
        sbyte(w, 8'h01, r);
        sbyte(w, v, r);
        desel(w);
        if (ok) begin
            nv[w] = v & 8'h9C;
            wel[w] = 0;
            bon[w] = 1;
            bt[w] = cyc;
        end
    endtask

    task automatic warr(input int w, input logic [7:0] op, input logic [7:0] ad, input logic [7:0] data[$]);
        logic [7:0] r;
        bit ok;
        int a;
        sel(w);
        ok = !mbusy(w) && wel[w];
        a = (w == 0) ? int'(ad[6:0]) : int'({op[3], ad});
        sbyte(w, op, r);
        sbyte(w, ad, r);
        foreach (data[k]) begin
            sbyte(w, data[k], r);
            if (ok) mm[w][a] = data[k];
            a = wrapa(a);
        end
        desel(w);
        if (ok && data.size() > 0) begin
            wel[w] = 0;
            bon[w] = 1;
            bt[w] = cyc;
        end
    endtask

    task automatic rarr(input int w, input logic [7:0] op, input logic [7:0] ad, input int n, input string tag);
        logic [7:0] r;
        bit ok;
        int a;
        sel(w);
        ok = !mbusy(w);
        a = (w == 0) ? int'(ad[6:0]) : int'({op[3], ad});
        sbyte(w, op, r);
        sbyte(w, ad, r);
        for (int k = 0; k < n; k++) begin
            sbyte(w, 8'h00, r);
            check(tag, r, ok ? mm[w][a] : 8'h00);
            a = wrapa(a);
        end
        desel(w);
    endtask

    task automatic settle();
        repeat (PROG + 50) @(negedge clk);
    endtask

    initial begin
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 512; a++) mm[w][a] = 8'h00;
            wel[w] = 0; nv[w] = 8'h00; bon[w] = 0; bt[w] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        rdsr(0, 1, "R1 status after reset");
        rarr(0, 8'h03, 8'h00, 2, "R1 array after reset");

        // R5 write without latch
        warr(0, 8'h02, 8'h05, '{8'hAA});
        rarr(0, 8'h03, 8'h05, 1, "R5 array write ignored");

        // R2 latch set/clear, R11 repeated status
        latch(0, 8'h06);
        rdsr(0, 2, "R2 R11 latch set, repeated status");
        latch(0, 8'h04);
        rdsr(0, 1, "R2 latch cleared");

        // R4 write wraps in block, R7 busy and latch clear
        latch(0, 8'h06);
        warr(0, 8'h02, 8'h0D, '{8'h11, 8'h22, 8'h33, 8'h44});
        rdsr(0, 1, "R7 busy set, latch cleared");
        // R8 commands ignored while busy
        latch(0, 8'h06);
        rarr(0, 8'h03, 8'h0D, 1, "R8 read while busy gives 0");
        settle();
        rdsr(0, 1, "R7 R8 busy ended, set-latch ignored");

        // R3 read with block wrap, upper address bit unused
        rarr(0, 8'h03, 8'h0E, 4, "R3 R4 read wraps in block");
        rarr(0, 8'h03, 8'h8D, 3, "R3 address bit 7 unused");

        // R6 status write
        latch(0, 8'h06);
        wrsr(0, 8'hFF);
        settle();
        rdsr(0, 1, "R6 status write stored");
        wrsr(0, 8'h00);
        rdsr(0, 1, "R5 status write without latch ignored");

        // R10 nine-bit address variant
        latch(1, 8'h06);
        warr(1, 8'h0A, 8'h10, '{8'h5A, 8'hA5});
        settle();
        rarr(1, 8'h0B, 8'h10, 2, "R10 upper half read");
        rarr(1, 8'h03, 8'h10, 2, "R10 lower half untouched");
        latch(1, 8'h06);
        warr(1, 8'h02, 8'h17, '{8'h77, 8'h88});
        settle();
        rarr(1, 8'h03, 8'h17, 2, "R10 R4 lower half write wraps");
        rarr(1, 8'h0B, 8'h10, 1, "R10 upper half kept");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule